// File: doc/BRIEF.md
# Programmable Square-Wave Frequency Generator

This block produces a square wave with equal high and low times. An 8-bit reload value sets the frequency. A fixed prescaler divides the input clock by eight. Each prescaled tick moves an 8-bit down-counter one step. When a tick finds the counter at zero, the output flips and the counter is refilled from the reload value. One half-period therefore lasts 8 × (N + 1) input clocks, and the output frequency is f_clk / (16 × (N + 1)).

Software writes and reads the reload value through a plain register port. The live counter can be read but has no write path. An enable input stands in for selecting the pin's alternate function. While the enable is low, the output is held low and the counter keeps a copy of the reload value, so that each run starts from a full period.

Top module: `sqwave_gen`

## Requirements
- R1: After reset, the reload readback, the counter readback and `wave_out` are all 0.
- R2: A value presented on `ctrl_wdata` with `ctrl_wr` high at a clock edge appears on `ctrl_rdata` after that edge.
- R3: While `enable` is low, `wave_out` is 0. One edge after a new reload value is written, `count_rdata` equals that value.
- R4: Once enabled, the counter holds its value for 8 clocks and then decrements by one. It keeps this rate of one step per 8 clocks.
- R5: A prescaled tick that finds the counter at 0 inverts `wave_out` and refills the counter from the reload value. The first inversion follows the enabling edge by 8 × (N + 1) clocks.
- R6: Successive inversions are exactly 8 × (N + 1) clocks apart (50% duty), and no other inversion occurs.
- R7: A reload value written while the block runs does not shorten the half-period in progress. It takes effect at the next refill.
- R8: The extremes N = 0 (inversion every 8 clocks) and N = 255 (inversion every 2048 clocks) behave as R5 and R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Alternate-function select. When low, the output is held low and the counter is preloaded. |
| ctrl_wr | input | 1 | Write strobe for the reload register |
| ctrl_wdata | input | 8 | Reload value to write |
| ctrl_rdata | output | 8 | Reload register readback |
| count_rdata | output | 8 | Live down-counter (read-only) |
| wave_out | output | 1 | Square-wave output |

## Verification
A write becomes visible on `ctrl_rdata` one edge later. While the block is disabled, `count_rdata` follows the new value one edge after that. After the enabling edge, the counter changes at edge 8. The k-th output inversion lands at edge k × 8 × (N + 1); for a reload written mid-run, the new spacing starts from the first refill. The driver task computes these edge numbers from the formula and queues them. The monitor samples on falling edges, pops the next entry at each output change, and compares it with a free-running edge counter, so an inversion that is early, late or extra is reported.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned SQW_CNT_W    = 8;
  localparam int unsigned SQW_PRESCALE = 8;
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PS_W = $clog2(DIV);
      localparam logic [PS_W-1:0] LAST = PS_W'(DIV - 1);
      logic [PS_W-1:0] ps_q;

      always_ff @(posedge clk) begin
        if (!rst_n)          ps_q <= '0;
        else if (!run)       ps_q <= '0;
        else if (ps_q == LAST) ps_q <= '0;
        else                 ps_q <= ps_q + 1'b1;
      end

      assign tick = run && (ps_q == LAST);

      // R4: a tick is never followed by another tick on the next edge.
      assert_tick_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sqw_period_cnt.sv
module sqw_period_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (!run)              count <= reload;
    else if (tick) begin
      if (count == '0)          count <= reload;
      else                      count <= count - 1'b1;
    end
  end

  assign wrap = tick && (count == '0);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count != '0) |=> count == $past(count) - 1'b1);
  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count));
  assert_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == '0) |=> count == $past(reload));
  assert_preload_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == $past(reload));
endmodule

// File: rtl/sqw_toggle.sv
module sqw_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wrap,
  output logic wave
);
  always_ff @(posedge clk) begin
    if (!rst_n)     wave <= 1'b0;
    else if (!run)  wave <= 1'b0;
    else if (wrap)  wave <= ~wave;
  end

  assert_flip_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> wave != $past(wave));
  assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(wave));
  assert_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wave);
endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W    = SQW_CNT_W,
  parameter int unsigned PRESCALE = SQW_PRESCALE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] ctrl_wdata,
  output logic [CNT_W-1:0] ctrl_rdata,
  output logic [CNT_W-1:0] count_rdata,
  output logic             wave_out
);
  logic [CNT_W-1:0] reload_q;
  logic             tick;
  logic             wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)       reload_q <= '0;
    else if (ctrl_wr) reload_q <= ctrl_wdata;
  end

  assert_wr_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_rdata == $past(ctrl_wdata));

  sqw_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick)
  );

  sqw_period_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick),
    .reload(reload_q), .count(count_rdata), .wrap(wrap)
  );

  sqw_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .run(enable), .wrap(wrap), .wave(wave_out)
  );

  assign ctrl_rdata = reload_q;
endmodule

// File: tb/sqwave_gen_tb_top.sv
module sqwave_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic [7:0] count_rdata;
  logic       wave_out;

  always #4 clk = ~clk;

  sqwave_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .count_rdata(count_rdata), .wave_out(wave_out)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  logic prev_wave = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor: every output change must match the next queued edge number.
  always @(negedge clk) begin
    int e;
    if (mon_on && wave_out !== prev_wave) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected inversion", cyc, -1);
      else begin
        e = exp_q.pop_front();
        check(cyc == e, "R5/R6 inversion edge", cyc, e);
      end
    end
    prev_wave = wave_out;
  end

  task automatic write_ctrl(input int v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = 8'(v);
    @(negedge clk);
    ctrl_wr = 1'b0;
    check(ctrl_rdata == 8'(v), "R2 reload readback", ctrl_rdata, v);
  endtask

  task automatic run_case(input int n, input int toggles);
    int c;
    int half;
    write_ctrl(n);
    @(negedge clk);
    check(count_rdata == 8'(n), "R3 preload while idle", count_rdata, n);
    half = 8 * (n + 1);
    prev_wave = wave_out;
    mon_on = 1'b1;
    c = cyc;
    enable = 1'b1;
    for (int k = 1; k <= toggles; k++) exp_q.push_back(c + half * k);
    if (n > 0) begin
      repeat (7) @(negedge clk);
      check(count_rdata == 8'(n), "R4 hold for 7 edges", count_rdata, n);
      @(negedge clk);
      check(count_rdata == 8'(n - 1), "R4 first step at edge 8", count_rdata, n - 1);
    end
    while (cyc < c + half * toggles + 2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all inversions seen", exp_q.size(), 0);
    mon_on = 1'b0;
    exp_q.delete();
    enable = 1'b0;
    @(negedge clk);
    check(wave_out == 1'b0, "R3 output low when disabled", wave_out, 0);
    check(count_rdata == 8'(n), "R3 counter preloaded when disabled", count_rdata, n);
  endtask

  initial begin
    int c;
    bit stayed_low;
    repeat (3) @(negedge clk);
    check(ctrl_rdata == 8'h00, "R1 reload reset", ctrl_rdata, 0);
    check(count_rdata == 8'h00, "R1 counter reset", count_rdata, 0);
    check(wave_out == 1'b0, "R1 output reset", wave_out, 0);
    rst_n = 1'b1;

    run_case(3, 3);   // R5 R6
    run_case(10, 4);  // R5 R6
    run_case(0, 4);   // R8 smallest period
    run_case(255, 3); // R8 largest period

    // R3: idle with a nonzero reload keeps output low
    write_ctrl(5);
    stayed_low = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (wave_out !== 1'b0) stayed_low = 1'b0;
    end
    check(stayed_low, "R3 idle output stays low", wave_out, 0);

    // R7: change reload mid-run, N=3 then 1
    write_ctrl(3);
    @(negedge clk);
    prev_wave = wave_out;
    mon_on = 1'b1;
    c = cyc;
    enable = 1'b1;
    exp_q.push_back(c + 32);
    exp_q.push_back(c + 48);
    exp_q.push_back(c + 64);
    repeat (5) @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = 8'd1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    while (cyc < c + 66) @(negedge clk);
    check(exp_q.size() == 0, "R7 new value at next refill", exp_q.size(), 0);
    mon_on = 1'b0;
    exp_q.delete();
    enable = 1'b0;
    @(negedge clk);
    check(count_rdata == 8'd1, "R3 preload after R7 run", count_rdata, 1);

    finish_run();
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end
endmodule